// File: doc/BRIEF.md
# Match-Compare Timer with Watchdog Channel

This peripheral keeps one free-running 32-bit up-counter, advanced by a tick-enable input, and compares it against six match registers. Each register is its own channel. When the counter equals a channel's match value, that channel raises a sticky status bit. Software clears a status bit by writing 1 to its position. Each channel drives an interrupt line, which is its status bit gated by its enable bit. The counter never clears on a match, so software schedules the next event by adding a delay to the current count and writing the sum into a match register.

The last channel, channel 5, can also act as a watchdog. When the watchdog enable and the channel 5 interrupt enable are both set, a match on channel 5 produces a one-cycle reset-request pulse. A system reset controller outside this block consumes that pulse. To pet the watchdog, software does the following:
1. Writes 1 to the latch command, which captures the counter into a snapshot register.
2. Reads the snapshot back.
3. Writes the snapshot plus the timeout into channel 5's match register.

Access is through a simple single-cycle register port. A write takes effect on the clock edge. A read returns data combinationally from the address.

Top module: `cmp_timer_wdog`

## Requirements
- R1: While reset is active and right after it: the counter, all match registers, the interrupt enables (0x24), the watchdog enable (0x28), the status bits (0x2C) and the snapshot (0x34) read 0, `irq` is 0 and `rst_req` is 0.
- R2: On every clock edge with `tick_en` high, the counter increments by 1, wrapping from 0xFFFFFFFF to 0. With `tick_en` low it holds. It does not clear on a match. It reads at 0x00, and writes to 0x00 are ignored.
- R3: Channel n (0 to 5) has a 32-bit read/write match register at offset 0x08 + 4*n.
- R4: The cycle after the counter equals channel n's match value, status bit n (bit n of 0x2C) reads 1. The bit stays set until a write to 0x2C with 1 in bit n. If a clear and a new match land in the same cycle, the match wins.
- R5: `irq[n]` is 1 exactly when status bit n and enable bit n of 0x24 are both 1.
- R6: A write to 0x30 with bit 0 set copies the counter value from before that edge into the snapshot at 0x34. A write with bit 0 clear leaves the snapshot unchanged.
- R7: Bit 0 of 0x28 is the watchdog enable. When it and bit 5 of 0x24 are set, the first cycle in which the counter equals channel 5's match value is followed by exactly one cycle of `rst_req` high.
- R8: If the watchdog enable or bit 5 of 0x24 is clear, matches on channel 5 produce no `rst_req`. Clearing the watchdog enable disarms the watchdog.
- R9: After a reset request, `rst_req` stays low even if the counter keeps equalling the channel 5 match value. It can fire again only after channel 5's match register is written.
- R10: Reads of unmapped or unaligned offsets (for example 0x20, 0x30, 0x3C) return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Counter advance enable |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 6 | Per-channel interrupt lines |
| rst_req | output | 1 | One-cycle system reset request from the watchdog channel |

## Verification
The assertions check several rules on every cycle:
- A reset request only ever follows a cycle in which the watchdog was armed and channel 5 matched.
- The request is never two cycles long.
- A match always leaves its status bit set on the next edge.
- Status bits only fall when a clear is written.
- The counter holds while the tick is low.

Some behaviour only the bench scenarios can show: that the request fires once and only once per programmed match while the counter is parked on the match value, and that it fires again after the match register is rewritten. The same applies to the snapshot capturing the pre-edge count, and to unmapped offsets staying inert. These are compared cycle by cycle against a behavioural model.

// File: rtl/cmp_timer_wdog.sv
module cmp_timer_wdog #(
  parameter int NCH     = 6,
  parameter int WDOG_CH = 5,
  parameter int AW      = 8,
  parameter int DW      = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic [NCH-1:0] irq,
  output logic          rst_req
);

  localparam logic [AW-1:0] A_CNT   = AW'(8'h00);
  localparam logic [AW-1:0] A_MATCH = AW'(8'h08);
  localparam logic [AW-1:0] A_IEN   = AW'(8'h24);
  localparam logic [AW-1:0] A_WDEN  = AW'(8'h28);
  localparam logic [AW-1:0] A_STAT  = AW'(8'h2C);
  localparam logic [AW-1:0] A_LATCH = AW'(8'h30);
  localparam logic [AW-1:0] A_SNAP  = AW'(8'h34);
  localparam logic [AW:0]   A_MEND  = (AW+1)'(8 + 4*NCH);

  logic [DW-1:0]  cnt, snap;
  logic [DW-1:0]  match [NCH];
  logic [NCH-1:0] ien, stat, hit, msel, stat_clr;
  logic           wden, fired, fire;
  logic [AW-1:0]  moff;
  logic           in_match;

  assign moff     = bus_addr - A_MATCH;
  assign in_match = (bus_addr >= A_MATCH) && ({1'b0, bus_addr} < A_MEND) && (bus_addr[1:0] == 2'b00);

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    assign msel[n] = in_match && (moff[AW-1:2] == (AW-2)'(n));
    assign hit[n]  = (cnt == match[n]);
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                 match[n] <= '0;
      else if (bus_we && msel[n]) match[n] <= bus_wdata;
  end

  assign stat_clr = (bus_we && bus_addr == A_STAT) ? bus_wdata[NCH-1:0] : '0;
  assign fire     = wden && ien[WDOG_CH] && hit[WDOG_CH] && !fired;
  assign irq      = stat & ien;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      snap    <= '0;
      ien     <= '0;
      wden    <= 1'b0;
      stat    <= '0;
      fired   <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      cnt     <= cnt + DW'(tick_en);
      stat    <= (stat & ~stat_clr) | hit;
      rst_req <= fire;
      fired   <= (bus_we && msel[WDOG_CH]) ? 1'b0 : (fired || fire);
      if (bus_we && bus_addr == A_IEN)                 ien  <= bus_wdata[NCH-1:0];
      if (bus_we && bus_addr == A_WDEN)                wden <= bus_wdata[0];
      if (bus_we && bus_addr == A_LATCH && bus_wdata[0]) snap <= cnt;
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int n = 0; n < NCH; n++)
      if (msel[n]) bus_rdata = match[n];
    case (bus_addr)
      A_CNT:   bus_rdata = cnt;
      A_IEN:   bus_rdata[NCH-1:0] = ien;
      A_WDEN:  bus_rdata[0] = wden;
      A_STAT:  bus_rdata[NCH-1:0] = stat;
      A_SNAP:  bus_rdata = snap;
      default: ;
    endcase
  end

  a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(cnt));
  a_r4_match_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
    ((hit[0] || hit[NCH-1] || hit != '0)) |=> (($past(hit) & ~stat) == '0));
  a_r4_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (stat != '0) |=> ((($past(stat) & ~$past(stat_clr)) & ~stat) == '0));
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  a_r8_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(wden && ien[WDOG_CH] && hit[WDOG_CH]));

endmodule

// File: tb/cmp_timer_wdog_tb.sv
module cmp_timer_wdog_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [5:0]  irq;
  logic        rst_req;

  int checks = 0, fails = 0, pulses = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cmp_timer_wdog u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .rst_req(rst_req));

  logic [31:0] m_cnt, m_snap;
  logic [31:0] m_match [6];
  logic [5:0]  m_ien, m_stat;
  logic        m_wden, m_fired, m_rst;

  function automatic logic [31:0] mread(input logic [7:0] a);
    if (a >= 8'h08 && a < 8'h20 && a[1:0] == 2'b00) return m_match[(a - 8'h08) >> 2];
    case (a)
      8'h00: return m_cnt;
      8'h24: return {26'b0, m_ien};
      8'h28: return {31'b0, m_wden};
      8'h2C: return {26'b0, m_stat};
      8'h34: return m_snap;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin : model
    logic [5:0] hv, clr;
    logic fire;
    logic wr5;
    if (!rst_n) begin
      m_cnt = 0; m_snap = 0; m_ien = 0; m_stat = 0; m_wden = 0; m_fired = 0; m_rst = 0;
      for (int n = 0; n < 6; n++) m_match[n] = 0;
    end else begin
      for (int n = 0; n < 6; n++) hv[n] = (m_cnt == m_match[n]);
      fire = m_wden && m_ien[5] && hv[5] && !m_fired;
      clr = (bus_we && bus_addr == 8'h2C) ? bus_wdata[5:0] : 6'h0;
      wr5 = bus_we && bus_addr == 8'h1C;
      if (bus_we && bus_addr == 8'h30 && bus_wdata[0]) m_snap = m_cnt;
      if (bus_we && bus_addr == 8'h24) m_ien = bus_wdata[5:0];
      if (bus_we && bus_addr == 8'h28) m_wden = bus_wdata[0];
      if (bus_we && bus_addr >= 8'h08 && bus_addr < 8'h20 && bus_addr[1:0] == 2'b00)
        m_match[(bus_addr - 8'h08) >> 2] = bus_wdata;
      m_stat = (m_stat & ~clr) | hv;
      m_fired = wr5 ? 1'b0 : (m_fired || fire);
      m_rst = fire;
      m_cnt = m_cnt + {31'b0, tick_en};
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      check("R3/R10 rdata per cycle", bus_rdata, mread(bus_addr));
      check("R5 irq per cycle", {26'b0, irq}, {26'b0, m_stat & m_ien});
      check("R7 rst_req per cycle", {31'b0, rst_req}, {31'b0, m_rst});
      if (rst_req) pulses++;
    end
  end

  task automatic cyc(input bit we, input logic [7:0] a, input logic [31:0] d);
    bus_we = we; bus_addr = a; bus_wdata = d;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 8'h00, 32'h0);
  endtask

  task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
    bus_we = 1'b0; bus_addr = a;
    #2;
    check(tag, bus_rdata, exp);
    @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 20000);
    checks++; fails++;
    $display("FAIL watchdog timeout actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] c;
    repeat (3) @(negedge clk);
    bus_addr = 8'h00; #1;
    check("R1 reset counter", bus_rdata, 0);
    check("R1 reset irq", {26'b0, irq}, 0);
    check("R1 reset rst_req", {31'b0, rst_req}, 0);
    bus_addr = 8'h2C; #1;
    check("R1 reset status", bus_rdata, 0);
    @(negedge clk);
    rst_n = 1'b1;
    rd("R1 match0 zero", 8'h08, 0);

    tick_en = 1'b1; idle(20);
    rd("R2 count after ticks", 8'h00, mread(8'h00));
    tick_en = 1'b0; c = mread(8'h00); idle(5);
    rd("R2 hold without tick", 8'h00, c);
    cyc(1'b1, 8'h00, 32'hFFFF_0000);
    rd("R2 counter write ignored", 8'h00, c);

    cyc(1'b1, 8'h0C, 32'h0000_1234);
    rd("R3 match1 readback", 8'h0C, 32'h0000_1234);
    for (int n = 0; n < 6; n++) cyc(1'b1, 8'(8 + 4*n), c + 32'(3 + 2*n));
    rd("R3 match5 readback", 8'h1C, c + 32'd13);
    cyc(1'b1, 8'h2C, 32'h3F);
    rd("R4 status cleared", 8'h2C, 0);
    cyc(1'b1, 8'h24, 32'h15);
    tick_en = 1'b1; idle(6); tick_en = 1'b0;
    rd("R4 status partial", 8'h2C, mread(8'h2C));
    check("R5 irq gated", {26'b0, irq}, {26'b0, m_stat & 6'h15});
    cyc(1'b1, 8'h2C, 32'h01);
    rd("R4 clear bit0", 8'h2C, mread(8'h2C));

    tick_en = 1'b1;
    cyc(1'b1, 8'h30, 32'h1);
    rd("R6 snapshot", 8'h34, mread(8'h34));
    c = mread(8'h34);
    cyc(1'b1, 8'h30, 32'h0);
    rd("R6 latch bit0 clear no effect", 8'h34, c);

    cyc(1'b1, 8'h20, 32'hDEAD_BEEF);
    rd("R10 unmapped 0x20", 8'h20, 0);
    rd("R10 read 0x30", 8'h30, 0);
    rd("R10 unaligned", 8'h0D, 0);
    rd("R10 0x3C", 8'h3C, 0);

    tick_en = 1'b0; c = mread(8'h00);
    cyc(1'b1, 8'h1C, c + 32'd4);
    cyc(1'b1, 8'h24, 32'h20);
    cyc(1'b1, 8'h28, 32'h1);
    pulses = 0;
    tick_en = 1'b1; idle(4); tick_en = 1'b0;
    idle(10);
    check("R7 one pulse", 32'(pulses), 1);
    check("R9 parked counter no refire", 32'(pulses), 1);
    cyc(1'b1, 8'h1C, c + 32'd4);
    idle(4);
    check("R9 refire after rewrite", 32'(pulses), 2);

    cyc(1'b1, 8'h28, 32'h0);
    c = mread(8'h00);
    cyc(1'b1, 8'h1C, c + 32'd3);
    pulses = 0;
    tick_en = 1'b1; idle(8);
    check("R8 wden clear no reset", 32'(pulses), 0);
    tick_en = 1'b0;
    cyc(1'b1, 8'h28, 32'h1);
    cyc(1'b1, 8'h24, 32'h1F);
    c = mread(8'h00);
    cyc(1'b1, 8'h1C, c + 32'd3);
    tick_en = 1'b1; idle(8); tick_en = 1'b0;
    check("R8 ien5 clear no reset", 32'(pulses), 0);
    rd("R2 no clear on match", 8'h00, c + 32'd8);

    idle(2);
    finish_run();
  end
endmodule